// File: doc/BRIEF.md
# 100 Mb/s Receive Carrier and Symbol Error Detector

This block sits behind the descrambler of a 100 Mb/s twisted-pair receiver. It takes the recovered code stream one bit per clock, together with a flag that says whether the descrambler is locked. From these it produces the nibble-wide media-independent receive outputs: a data-valid strobe, an error strobe and a 4-bit data nibble.

On an idle line the stream is all ones. The block watches a 10-bit sliding window for the first zero that follows idle. When that zero has moved to the third-oldest position, the block classifies the window. An exact start-of-stream pair (code groups 11000 then 10001) opens a frame. Any other window that holds two zeros with a gap between them is reported as a false carrier. Anything less is treated as line noise.

Inside a frame, each 5-bit code group is mapped to a nibble, one symbol later than it arrives. The block looks ahead by one group so that it can confirm the end-of-stream pair (01101 then 00111) before it drops data-valid. Invalid code groups, premature idle and loss of descrambler lock are all signalled on the error output.

Top module: `rx100_carrier_detect`

## Requirements
- R1: Out of reset, and while the stream is all ones, rx_dv and rx_er are 0 and rxd is 0000.
- R2: A window equal to 11000 10001 (oldest bit first) starts a frame. Two preamble nibbles 0101 follow with rx_dv=1 and rx_er=0. The first of them appears on the clock edge after the one that shifts in the last bit of the second delimiter group.
- R3: A window that holds two zeros at least two positions apart, has its first zero after at least two ones, and is not the start pair raises false carrier: rx_er=1, rxd=1110, rx_dv=0.
- R4: False carrier is held, with every later bit ignored, until the window holds ten consecutive ones. All three outputs return to 0 on the edge after that.
- R5: A single zero, or a run of two adjacent zeros, surrounded by ones does not start a frame and does not raise false carrier.
- R6: Each in-frame data group is decoded on rxd (with rx_dv=1 and rx_er=0) by the 4B5B table: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R7: The pair 01101 then 00111 ends the frame. In the slot after the last data nibble, rx_dv and rx_er are 0 and rxd is 0000. A new start pair that follows later is accepted.
- R8: An in-frame group that is not data, and is not the first group of a valid end pair, is output with rx_dv=1, rx_er=1 and rxd=0000. Data that follows is decoded normally.
- R9: An end-delimiter first group (01101) that is not followed by 00111 is output as an error symbol (rx_dv=1, rx_er=1), and the frame continues.
- R10: Two idle groups (11111 11111) before an end pair produce one error symbol (rx_dv=1, rx_er=1). All outputs are 0 in the next slot.
- R11: When rx_lock is low on any clock of a frame symbol, that symbol's slot carries rx_dv=1 and rx_er=1. The next slot drops to all zeros, and the rest of the stream is ignored until ten consecutive ones are seen.
- R12: The outputs change only at 5-clock symbol boundaries during a frame. Any rise of rx_er lasts at least two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one code bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Descrambled code bit, first bit of each group first |
| rx_lock | input | 1 | High while the descrambler is locked |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error / false carrier strobe |
| rxd | output | 4 | Receive data nibble |

## Verification
The bench walks every entry of the 4B5B table through one frame and checks that each nibble lands in its own 5-clock slot. A design with an off-by-one symbol phase or a wrong table entry would put a nibble in the wrong slot or decode a wrong value. Noise patterns that hold only a lone zero or an adjacent zero pair must leave the outputs silent, whereas a pair of separated zeros must raise the 1110 false-carrier code and keep it through later garbage zeros; a detector that counted zeros without looking at their spacing, or that left false carrier too early, would fail one of these. An end group followed by data, two idles inside a frame, and a one-bit lock drop must each produce exactly one error slot. In the lock case the remainder of the frame must not be misread as false carrier, and a back-to-back frame after a clean end must still be accepted, which catches a window that is not cleared at end of frame.

// File: rtl/rx100_pkg.sv
// Shared constants, types and the 4B5B decode function for the
// 100 Mb/s receive carrier detector. Assumes 5-bit code groups sent
// first bit first, mapped to 4-bit nibbles.
package rx100_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_FALSE_CS = 4'b1110;
    localparam logic [NIB_W-1:0] NIB_ZERO     = 4'b0000;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SSDK  = 3'd1,
        ST_FRAME = 3'd2,
        ST_ABORT = 3'd3,
        ST_DRAIN = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic             is_data;
        logic             is_idle;
        logic             is_t;
        logic [NIB_W-1:0] nib;
    } sym_class_t;

    // Map one code group to {valid, nibble}; valid is 0 for non-data codes.
    function automatic logic [NIB_W:0] dec4b5b(input logic [SYM_W-1:0] cg);
        logic [NIB_W:0] r;
        case (cg)
            5'b11110: r = {1'b1, 4'h0};
            5'b01001: r = {1'b1, 4'h1};
            5'b10100: r = {1'b1, 4'h2};
            5'b10101: r = {1'b1, 4'h3};
            5'b01010: r = {1'b1, 4'h4};
            5'b01011: r = {1'b1, 4'h5};
            5'b01110: r = {1'b1, 4'h6};
            5'b01111: r = {1'b1, 4'h7};
            5'b10010: r = {1'b1, 4'h8};
            5'b10011: r = {1'b1, 4'h9};
            5'b10110: r = {1'b1, 4'hA};
            5'b10111: r = {1'b1, 4'hB};
            5'b11010: r = {1'b1, 4'hC};
            5'b11011: r = {1'b1, 4'hD};
            5'b11100: r = {1'b1, 4'hE};
            5'b11101: r = {1'b1, 4'hF};
            default:  r = {1'b0, 4'h0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx100_bit_window.sv
// Sliding window over the serial code stream.
// Holds the last WIN_W bits, oldest in the MSB. A flush reloads it with
// ones (keeping the bit arriving that cycle), so stale frame bits cannot
// look like a fresh carrier. Also derives the carrier-candidate,
// separated-zero and all-ones flags from the registered window.
module rx100_bit_window #(
    parameter int WIN_W  = 10,
    parameter int LEAD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             flush,
    output logic [WIN_W-1:0] win,
    output logic             cand,
    output logic             zero_gap,
    output logic             all_ones
);
    localparam int ZPOS = WIN_W - LEAD_W - 1;

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] zeros;
    logic [WIN_W-1:0] gap_terms;

    // Shift one bit per clock; reload with ones on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '1;
        end else if (flush) begin
            win_q <= {{(WIN_W-1){1'b1}}, bit_in};
        end else begin
            win_q <= {win_q[WIN_W-2:0], bit_in};
        end
    end

    assign zeros = ~win_q;

    // One term per distance: some zero pair is exactly k positions apart.
    generate
        for (genvar k = 0; k < WIN_W; k++) begin : g_gap
            if (k < 2) begin : g_none
                assign gap_terms[k] = 1'b0;
            end else begin : g_dist
                assign gap_terms[k] = |(zeros & (zeros >> k));
            end
        end
    endgenerate

    assign win      = win_q;
    assign zero_gap = |gap_terms;
    assign all_ones = &win_q;
    // First zero after at least LEAD_W ones has reached the alignment point.
    assign cand     = (&win_q[WIN_W-1 -: LEAD_W]) && !win_q[ZPOS];

endmodule

// File: rtl/rx100_sym_class.sv
// Classifies one 5-bit code group: data (with its nibble), idle, or the
// first end-delimiter group. Purely combinational.
module rx100_sym_class
    import rx100_pkg::*;
(
    input  logic [SYM_W-1:0] cg,
    output sym_class_t       cls
);
    logic [NIB_W:0] dec;

    // Table lookup and delimiter compares.
    always_comb begin
        dec         = dec4b5b(cg);
        cls.is_data = dec[NIB_W];
        cls.nib     = dec[NIB_W-1:0];
        cls.is_idle = (cg == CG_IDLE);
        cls.is_t    = (cg == CG_T);
    end

endmodule

// File: rtl/rx100_frame_fsm.sv
// Receive framing state machine. It detects the start pair or a false
// carrier from the window flags. During a frame it emits one output
// slot per symbol for the older group of the window, using the newer
// group as lookahead. It also tracks loss of lock within each symbol.
// Assumes the window module flags are derived from registered state.
module rx100_frame_fsm
    import rx100_pkg::*;
#(
    parameter int CNT_W = $clog2(SYM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand,
    input  logic             is_ssd,
    input  logic             zero_gap,
    input  logic             all_ones,
    input  sym_class_t       prev_cls,
    input  logic             cur_idle,
    input  logic             cur_r,
    input  logic             lock,
    output logic             flush,
    output logic             dv,
    output logic             er,
    output logic [NIB_W-1:0] nib
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W);

    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lost_q, lost_d, lost_now;
    logic             dv_q, dv_d, er_q, er_d;
    logic [NIB_W-1:0] nib_q, nib_d;
    logic             boundary, restart;

    assign boundary = (cnt_q == CNT_LAST);
    assign lost_now = lost_q | !lock;

    // Next-state and output-slot decisions.
    always_comb begin
        st_d    = st_q;
        dv_d    = dv_q;
        er_d    = er_q;
        nib_d   = nib_q;
        flush   = 1'b0;
        restart = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cand && is_ssd) begin
                    st_d    = ST_SSDK;
                    dv_d    = 1'b1;
                    er_d    = 1'b0;
                    nib_d   = NIB_PREAMBLE;
                    restart = 1'b1;
                end else if (cand && zero_gap) begin
                    st_d  = ST_DRAIN;
                    dv_d  = 1'b0;
                    er_d  = 1'b1;
                    nib_d = NIB_FALSE_CS;
                end else if (boundary) begin
                    dv_d  = 1'b0;
                    er_d  = 1'b0;
                    nib_d = NIB_ZERO;
                end
            end
            ST_SSDK: begin
                if (boundary) begin
                    if (lost_now) begin
                        st_d  = ST_ABORT;
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                        nib_d = NIB_ZERO;
                    end else begin
                        st_d  = ST_FRAME;
                        dv_d  = 1'b1;
                        er_d  = 1'b0;
                        nib_d = NIB_PREAMBLE;
                    end
                end
            end
            ST_FRAME: begin
                if (boundary) begin
                    if (lost_now) begin
                        st_d  = ST_ABORT;
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                        nib_d = NIB_ZERO;
                    end else if (prev_cls.is_t && cur_r) begin
                        st_d  = ST_IDLE;
                        dv_d  = 1'b0;
                        er_d  = 1'b0;
                        nib_d = NIB_ZERO;
                        flush = 1'b1;
                    end else if (prev_cls.is_idle && cur_idle) begin
                        st_d  = ST_IDLE;
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                        nib_d = NIB_ZERO;
                        flush = 1'b1;
                    end else if (prev_cls.is_data) begin
                        dv_d  = 1'b1;
                        er_d  = 1'b0;
                        nib_d = prev_cls.nib;
                    end else begin
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                        nib_d = NIB_ZERO;
                    end
                end
            end
            ST_ABORT: begin
                if (boundary) begin
                    st_d  = ST_DRAIN;
                    dv_d  = 1'b0;
                    er_d  = 1'b0;
                    nib_d = NIB_ZERO;
                end
            end
            ST_DRAIN: begin
                if (all_ones) begin
                    st_d  = ST_IDLE;
                    dv_d  = 1'b0;
                    er_d  = 1'b0;
                    nib_d = NIB_ZERO;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                dv_d  = 1'b0;
                er_d  = 1'b0;
                nib_d = NIB_ZERO;
            end
        endcase
        cnt_d  = (restart || boundary) ? CNT_ONE : cnt_q + CNT_ONE;
        lost_d = (restart || boundary) ? 1'b0 : lost_now;
    end

    // State, symbol phase, lock tracker and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= CNT_ONE;
            lost_q <= 1'b0;
            dv_q   <= 1'b0;
            er_q   <= 1'b0;
            nib_q  <= NIB_ZERO;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            lost_q <= lost_d;
            dv_q   <= dv_d;
            er_q   <= er_d;
            nib_q  <= nib_d;
        end
    end

    assign dv  = dv_q;
    assign er  = er_q;
    assign nib = nib_q;

    // R3: error without valid is always the false-carrier code.
    p_false_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (er_q && !dv_q) |-> (nib_q == NIB_FALSE_CS));

    // R2: valid can only rise on the preamble nibble.
    p_dv_rise_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_q) |-> (nib_q == NIB_PREAMBLE) && !er_q);

    // R12: an error indication lasts past a single clock.
    p_er_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(er_q) |=> er_q);

    // R7: valid never falls while an error is being reported.
    p_dv_fall_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_q) |-> !er_q);

    // R4: while draining ignored input, valid stays low.
    p_drain_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN) |-> !dv_q);

    // R12: in a frame, outputs move only at a symbol boundary.
    p_slot_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FRAME) && !boundary) |=> $stable({dv_q, er_q, nib_q}));

endmodule

// File: rtl/rx100_carrier_detect.sv
// Top of the 100 Mb/s receive carrier and symbol error detector.
// Serial descrambled bits enter a 10-bit window. The older and newer
// halves are classified, and the framing FSM drives the nibble outputs.
// Assumes one code bit per clock and a lock flag from the descrambler.
module rx100_carrier_detect
    import rx100_pkg::*;
#(
    parameter int WIN_W = 2 * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_lock,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd
);
    localparam logic [WIN_W-1:0] SSD_PAIR = {CG_J, CG_K};

    logic [WIN_W-1:0] win;
    logic             cand, zero_gap, all_ones, flush;
    logic             is_ssd, cur_idle, cur_r;
    logic [SYM_W-1:0] prev_cg, cur_cg;
    sym_class_t       prev_cls;

    rx100_bit_window #(.WIN_W(WIN_W), .LEAD_W(2)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .flush    (flush),
        .win      (win),
        .cand     (cand),
        .zero_gap (zero_gap),
        .all_ones (all_ones)
    );

    // Split the window into the older and newer code groups.
    always_comb begin
        prev_cg  = win[WIN_W-1 -: SYM_W];
        cur_cg   = win[SYM_W-1:0];
        is_ssd   = (win == SSD_PAIR);
        cur_idle = (cur_cg == CG_IDLE);
        cur_r    = (cur_cg == CG_R);
    end

    rx100_sym_class u_prev (
        .cg  (prev_cg),
        .cls (prev_cls)
    );

    rx100_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .is_ssd   (is_ssd),
        .zero_gap (zero_gap),
        .all_ones (all_ones),
        .prev_cls (prev_cls),
        .cur_idle (cur_idle),
        .cur_r    (cur_r),
        .lock     (rx_lock),
        .flush    (flush),
        .dv       (rx_dv),
        .er       (rx_er),
        .nib      (rxd)
    );

endmodule

// File: tb/sim_rx100_carrier_detect.sv
module sim_rx100_carrier_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b1;
    logic       rx_lock = 1'b1;
    logic       rx_dv, rx_er;
    logic [3:0] rxd;

    int tests = 0;
    int fails = 0;

    logic       sbit  [0:1023];
    logic       slock [0:1023];
    logic [5:0] logv  [0:1023];
    int         slen;

    always #5 clk = ~clk;

    rx100_carrier_detect u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_lock(rx_lock),
        .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd)
    );

    function automatic logic [4:0] enc(input int n);
        case (n)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;
            3: return 5'b10101;  4: return 5'b01010;  5: return 5'b01011;
            6: return 5'b01110;  7: return 5'b01111;  8: return 5'b10010;
            9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
           12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100;
           default: return 5'b11101;
        endcase
    endfunction

    // Sample point in the middle of output slot m of a frame whose J starts at bit s.
    function automatic int slot(input int s, input int m);
        return s + 13 + 5 * m;
    endfunction

    task automatic clear_stream();
        slen = 0;
    endtask

    task automatic put_sym(input logic [4:0] v);
        for (int i = 4; i >= 0; i--) begin
            sbit[slen]  = v[i];
            slock[slen] = 1'b1;
            slen++;
        end
    endtask

    task automatic put_ones(input int n);
        for (int i = 0; i < n; i++) begin
            sbit[slen]  = 1'b1;
            slock[slen] = 1'b1;
            slen++;
        end
    endtask

    task automatic run_stream();
        for (int c = 0; c < slen; c++) begin
            @(negedge clk);
            logv[c] = {rx_dv, rx_er, rxd};
            rx_bit  = sbit[c];
            rx_lock = slock[c];
        end
        @(negedge clk);
        rx_bit  = 1'b1;
        rx_lock = 1'b1;
    endtask

    task automatic check(input string req, input int idx, input logic [5:0] exp);
        tests++;
        if (logv[idx] !== exp) begin
            fails++;
            $display("FAIL %s at bit %0d: got %b expected %b", req, idx, logv[idx], exp);
        end
    endtask

    task automatic check_quiet(input string req, input int from, input int to);
        int bad = -1;
        tests++;
        for (int c = from; c <= to; c++)
            if (bad < 0 && (logv[c][5] !== 1'b0 || logv[c][4] !== 1'b0)) bad = c;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s at bit %0d: got %b expected dv=0 er=0", req, bad, logv[bad]);
        end
    endtask

    // R1: reset state and an idle stream.
    task automatic t_reset_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        tests++;
        if ({rx_dv, rx_er, rxd} !== 6'b000000) begin
            fails++;
            $display("FAIL R1 reset: got %b expected 000000", {rx_dv, rx_er, rxd});
        end
        rst_n = 1'b1;
        clear_stream();
        put_ones(40);
        run_stream();
        check_quiet("R1 idle", 0, 39);
        check("R1 idle rxd", 39, 6'b000000);
    endtask

    // R2, R6, R7, R12: full table in one frame, then a back-to-back frame.
    task automatic t_normal_frame();
        int s, s2;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        for (int i = 0; i < 16; i++) put_sym(enc(i));
        put_sym(5'b01101); put_sym(5'b00111);
        put_ones(10);
        s2 = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        put_sym(enc(10));
        put_sym(5'b01101); put_sym(5'b00111);
        put_ones(30);
        run_stream();
        check("R2 quiet before start", s + 10, 6'b000000);
        check("R2 first preamble edge", s + 11, 6'b100101);
        check("R2 preamble J", slot(s, 0), 6'b100101);
        check("R2 preamble K", slot(s, 1), 6'b100101);
        for (int i = 0; i < 16; i++)
            check("R6 data nibble", slot(s, 2 + i), {2'b10, 4'(i)});
        check("R12 slot start", slot(s, 2) - 2, {2'b10, 4'h0});
        check("R12 slot end", slot(s, 2) + 2, {2'b10, 4'h0});
        check("R7 end of frame", slot(s, 18), 6'b000000);
        check_quiet("R7 gap quiet", slot(s, 18), s2 + 10);
        check("R7 second preamble", slot(s2, 0), 6'b100101);
        check("R7 second data", slot(s2, 2), 6'b101010);
        check("R7 second end", slot(s2, 3), 6'b000000);
    endtask

    // R3, R4: separated zeros start false carrier, garbage is ignored.
    task automatic t_false_carrier();
        int s, z;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b10101);
        put_sym(5'b00000);
        put_sym(5'b01010);
        z = slen - 1;
        put_ones(30);
        run_stream();
        check("R3 quiet before detect", s + 9, 6'b000000);
        check("R3 false carrier code", s + 12, 6'b011110);
        check("R4 held through garbage", z + 10, 6'b011110);
        check("R4 released after ones", z + 13, 6'b000000);
        check_quiet("R4 idle afterwards", z + 13, slen - 1);
    endtask

    // R5: lone and adjacent zeros are noise.
    task automatic t_noise();
        clear_stream();
        put_ones(20);
        sbit[slen] = 1'b0; slock[slen] = 1'b1; slen++;
        put_ones(12);
        sbit[slen] = 1'b0; slock[slen] = 1'b1; slen++;
        sbit[slen] = 1'b0; slock[slen] = 1'b1; slen++;
        put_ones(25);
        run_stream();
        check_quiet("R5 no carrier on noise", 0, slen - 1);
        check("R5 rxd stays zero", slen - 1, 6'b000000);
    endtask

    // R8: an invalid code inside a frame.
    task automatic t_bad_code();
        int s;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        put_sym(enc(3)); put_sym(5'b00000); put_sym(enc(7));
        put_sym(5'b01101); put_sym(5'b00111);
        put_ones(25);
        run_stream();
        check("R8 data before", slot(s, 2), 6'b100011);
        check("R8 invalid code", slot(s, 3), 6'b110000);
        check("R8 data after", slot(s, 4), 6'b100111);
        check("R8 clean end", slot(s, 5), 6'b000000);
    endtask

    // R9: first end group without its partner.
    task automatic t_lone_t();
        int s;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        put_sym(enc(1)); put_sym(5'b01101); put_sym(enc(2));
        put_sym(5'b01101); put_sym(5'b00111);
        put_ones(25);
        run_stream();
        check("R9 data before", slot(s, 2), 6'b100001);
        check("R9 lone end group", slot(s, 3), 6'b110000);
        check("R9 frame continues", slot(s, 4), 6'b100010);
        check("R9 proper end", slot(s, 5), 6'b000000);
    endtask

    // R10: idles before the end pair.
    task automatic t_early_idle();
        int s;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        put_sym(enc(1)); put_sym(enc(2));
        put_ones(40);
        run_stream();
        check("R10 data", slot(s, 3), 6'b100010);
        check("R10 premature idle", slot(s, 4), 6'b110000);
        check("R10 drop after", slot(s, 5), 6'b000000);
        check_quiet("R10 stays idle", slot(s, 5), slen - 1);
    endtask

    // R11: a one-bit lock drop mid-frame.
    task automatic t_lock_loss();
        int s;
        clear_stream();
        put_ones(20);
        s = slen;
        put_sym(5'b11000); put_sym(5'b10001);
        for (int i = 1; i <= 4; i++) put_sym(enc(i));
        put_sym(5'b01101); put_sym(5'b00111);
        put_ones(30);
        slock[s + 21] = 1'b0;
        run_stream();
        check("R11 data before", slot(s, 2), 6'b100001);
        check("R11 lost lock slot", slot(s, 3), 6'b110000);
        check("R11 drop after", slot(s, 4), 6'b000000);
        check_quiet("R11 remainder ignored", slot(s, 4), slen - 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_normal_frame();
        t_false_carrier();
        t_noise();
        t_bad_code();
        t_lone_t();
        t_early_idle();
        t_lock_loss();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule